// File: doc/BRIEF.md
# Audio Sample Block Fetcher

This block walks a circular audio buffer in main memory, one 32-byte block per sample tick, and asks the memory system for each block. A 32-byte block carries eight stereo frames of 16-bit samples. Software programs a block-aligned start address and a block count, then sets an enable bit. From then on every tick fetches the next block. When the buffer runs out, the pointer goes back to the start and an interrupt request is raised, so software can refill the half it has just released.

Four 16-bit registers form the programming interface. Index 0 is the upper half of the start address. Index 1 is the lower half. Index 2 is control: bit 15 is the enable and bits 14:0 are the block count. Index 3 is a read-only count of the blocks left. Rewriting the start or the count while the block runs does not disturb the buffer in flight. The new values take effect at the next wrap. A separate core-reset input clears the control register.

Top module: `audio_dma_seq`

## Requirements
- R1: A write to index 0 keeps only bits 9:0 of the data, or bits 12:0 when `ext_mem_mode` is 1 during the write. The masked value reads back at index 0.
- R2: A write to index 1 keeps only bits 15:5, so every fetch address is a multiple of 32.
- R3: When a control write takes bit 15 from 0 to 1, the current address is loaded from the start address and the remaining count from bits 14:0 of the written data.
- R4: A tick while enabled with a nonzero remaining count pulses `mem_req` for one cycle, one clock after the tick, with `mem_addr` equal to the current address. The address then advances by 32 and the count drops by one.
- R5: On an enabled tick that leaves the remaining count at zero (including a count that was already zero), the current address and count reload from the programmed start and control count, and `irq` pulses one clock after the tick.
- R6: Writes to index 0, 1 or 2 while the enable is already set change only the programmed values. The buffer in progress keeps its address sequence until the next wrap.
- R7: A read of index 3 returns the remaining count minus one, or 0 when the count is 0. Writes to index 3 change nothing.
- R8: After an enabling control write, `irq` pulses exactly 200 clock cycles later (parameter `START_DELAY`).
- R9: A tick while the enable is clear produces no `mem_req` and no `irq`.
- R10: A cycle with `core_reset` high clears the whole control register, including the enable.
- R11: `irq` is a single-cycle pulse.
- R12: After reset, all four registers read 0 and `mem_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 address high, 1 address low, 2 control, 3 blocks left |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| ext_mem_mode | input | 1 | Widens the address-high write mask |
| core_reset | input | 1 | Clears the control register |
| tick | input | 1 | Sample-block tick, one block per pulse |
| mem_req | output | 1 | Block fetch request strobe |
| mem_addr | output | 32 | Byte address of the requested block |
| irq | output | 1 | Audio interrupt request pulse |

## Verification
A wrong current address shows up on `mem_addr` at the very next enabled tick. A wrong remaining count shows up at once in the index-3 readback, and it moves the `irq` pulse to the wrong tick at the next wrap. A stale or early reload is only visible when the buffer wraps, so reprogramming while enabled is followed by enough ticks to cross at least one wrap. An error in the start-delay counter shifts the first `irq` by at least one cycle, and the bench checks the pulse against the exact cycle.

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int          BLOCK_BYTES = 32,
  parameter int          START_DELAY = 200,
  parameter logic [15:0] HI_MASK_STD = 16'h03ff,
  parameter logic [15:0] HI_MASK_EXT = 16'h1fff
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ext_mem_mode,
  input  logic        core_reset,
  input  logic        tick,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic        irq
);
  localparam logic [15:0] LO_MASK = 16'(~(BLOCK_BYTES - 1));
  localparam int          DLY_W   = $clog2(START_DELAY + 1);
  localparam logic [1:0]  A_HI = 2'd0, A_LO = 2'd1, A_CTL = 2'd2, A_LEFT = 2'd3;

  logic [15:0]      src_hi, src_lo, ctl;
  logic [31:0]      cur;
  logic [14:0]      rem;
  logic [DLY_W-1:0] dly;

  wire        en      = ctl[15];
  wire        ctl_wr  = reg_wr && reg_addr == A_CTL && !core_reset;
  wire        start   = ctl_wr && reg_wdata[15] && !en;
  wire        stop    = core_reset || (ctl_wr && !reg_wdata[15]);
  wire        step    = tick && en;
  wire [14:0] rem_dec = (rem != 15'd0) ? rem - 15'd1 : rem;
  wire        wrap    = step && rem_dec == 15'd0;

  always_comb begin
    case (reg_addr)
      A_HI:    reg_rdata = src_hi;
      A_LO:    reg_rdata = src_lo;
      A_CTL:   reg_rdata = ctl;
      default: reg_rdata = {1'b0, rem_dec};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_hi   <= '0;
      src_lo   <= '0;
      ctl      <= '0;
      cur      <= '0;
      rem      <= '0;
      dly      <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      irq      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      irq     <= 1'b0;

      if (reg_wr && reg_addr == A_HI)
        src_hi <= reg_wdata & (ext_mem_mode ? HI_MASK_EXT : HI_MASK_STD);
      if (reg_wr && reg_addr == A_LO)
        src_lo <= reg_wdata & LO_MASK;

      if (core_reset)  ctl <= '0;
      else if (ctl_wr) ctl <= reg_wdata;

      if (start) begin
        cur <= {src_hi, src_lo};
        rem <= reg_wdata[14:0];
      end else if (step) begin
        if (rem != 15'd0) begin
          mem_req  <= 1'b1;
          mem_addr <= cur;
        end
        if (wrap) begin
          cur <= {src_hi, src_lo};
          rem <= ctl[14:0];
          irq <= 1'b1;
        end else begin
          cur <= cur + 32'(BLOCK_BYTES);
          rem <= rem_dec;
        end
      end

      if (start)
        dly <= DLY_W'(START_DELAY);
      else if (stop)
        dly <= '0;
      else if (dly != '0) begin
        dly <= dly - 1'b1;
        if (dly == DLY_W'(1)) irq <= 1'b1;
      end
    end
  end
endmodule

module audio_dma_seq_chk #(
  parameter int BLOCK_BYTES = 32,
  parameter int START_DELAY = 200,
  parameter int DLY_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             core_reset,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             mem_req,
  input logic [31:0]      mem_addr,
  input logic             irq,
  input logic             en,
  input logic [14:0]      rem,
  input logic [DLY_W-1:0] dly
);
  // R2
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & 32'(BLOCK_BYTES - 1)) == 32'd0);
  // R9
  req_needs_enabled_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(tick) && $past(en));
  // R4
  count_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && en && rem > 15'd1 |=> rem == $past(rem) - 15'd1);
  // R7
  left_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd3 && !tick |=> rem == $past(rem));
  // R10
  core_reset_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !en);
  // R8
  delay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> dly == DLY_W'(START_DELAY));
  // R5
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dly == DLY_W'(1)) || $past(tick && en));
endmodule

bind audio_dma_seq audio_dma_seq_chk #(
  .BLOCK_BYTES(BLOCK_BYTES), .START_DELAY(START_DELAY), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .core_reset(core_reset),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .mem_req(mem_req), .mem_addr(mem_addr),
  .irq(irq), .en(en), .rem(rem), .dly(dly)
);

// File: tb/tb_audio_dma_seq.sv
module tb_audio_dma_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, ext_mem_mode = 1'b0, core_reset = 1'b0, tick = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic        mem_req, irq;
  logic [31:0] mem_addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [15:0] m_hi = 0, m_lo = 0, m_ctl = 0;
  logic [31:0] m_cur = 0;
  logic [14:0] m_rem = 0;

  always #10 clk = ~clk;

  audio_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_mem_mode(ext_mem_mode),
    .core_reset(core_reset), .tick(tick), .mem_req(mem_req),
    .mem_addr(mem_addr), .irq(irq)
  );

  function automatic logic [15:0] hi_mask(logic [15:0] d, logic ext);
    return d & (ext ? 16'h1fff : 16'h03ff);
  endfunction

  function automatic logic [15:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_hi;
      2'd1: return m_lo;
      2'd2: return m_ctl;
      default: return (m_rem == 0) ? 16'd0 : {1'b0, m_rem - 15'd1};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      2'd0: m_hi = hi_mask(d, ext_mem_mode);
      2'd1: m_lo = d & 16'hffe0;
      2'd2: begin
        if (d[15] && !m_ctl[15]) begin m_cur = {m_hi, m_lo}; m_rem = d[14:0]; end
        m_ctl = d;
      end
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [1:0] a);
    reg_addr = a;
    #2;
    chk(req, {16'd0, reg_rdata}, {16'd0, model_read(a)});
  endtask

  task automatic do_tick(string req);
    logic        er, ei;
    logic [31:0] ea;
    er = 1'b0; ei = 1'b0; ea = 32'd0;
    if (m_ctl[15]) begin
      if (m_rem != 0) begin er = 1'b1; ea = m_cur; m_rem--; m_cur += 32; end
      if (m_rem == 0) begin m_cur = {m_hi, m_lo}; m_rem = m_ctl[14:0]; ei = 1'b1; end
    end
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk({req, " mem_req"}, {31'd0, mem_req}, {31'd0, er});
    if (er) chk({req, " mem_addr"}, mem_addr, ea);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, ei});
    @(negedge clk);
    chk("R11 irq single cycle", {31'd0, irq}, 32'd0);
  endtask

  task automatic wait_start();
    repeat (199) @(negedge clk);
    chk("R8 irq not before 200", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R8 irq at 200", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R11 start irq one cycle", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) rd("R12 reg reset", 2'(a));

    wr(2'd0, 16'hffff); rd("R1 std mask", 2'd0);
    ext_mem_mode = 1'b1;
    wr(2'd0, 16'hffff); rd("R1 ext mask", 2'd0);
    ext_mem_mode = 1'b0;
    wr(2'd0, 16'h0012);
    wr(2'd1, 16'h345f); rd("R2 low mask", 2'd1);

    do_tick("R9 disabled tick");

    wr(2'd2, 16'h8003);
    rd("R3 count loaded", 2'd3);
    wait_start();
    do_tick("R3 R4 first block");
    rd("R7 left after tick", 2'd3);
    do_tick("R4 second block");
    do_tick("R5 wrap");
    rd("R5 count reloaded", 2'd3);

    wr(2'd0, 16'h0040);
    wr(2'd2, 16'h8002);
    rd("R6 ctl reprogrammed", 2'd2);
    do_tick("R6 old buffer continues");
    wr(2'd3, 16'h7fff);
    rd("R7 write ignored", 2'd3);
    do_tick("R6 old buffer ends");
    do_tick("R6 new buffer start");
    do_tick("R6 new buffer wrap");

    wr(2'd2, 16'h0000);
    wr(2'd2, 16'h8000);
    rd("R7 saturates at zero", 2'd3);
    wait_start();
    do_tick("R5 zero count wrap");

    @(negedge clk); core_reset = 1'b1;
    @(negedge clk); core_reset = 1'b0;
    m_ctl = 16'd0;
    rd("R10 ctl cleared", 2'd2);
    do_tick("R10 tick after core reset");

    wr(2'd2, {1'b1, 15'(1 + $urandom_range(0, 4))});
    wait_start();
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 5) do_tick("R4 R5 random tick");
      else if (op == 6) begin
        ext_mem_mode = 1'($urandom_range(0, 1));
        wr(2'd0, 16'($urandom));
        ext_mem_mode = 1'b0;
      end
      else if (op == 7) wr(2'd1, 16'($urandom));
      else if (op == 8) wr(2'd2, {1'b1, 15'($urandom_range(0, 5))});
      else rd("R6 R7 random read", 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule